// File: doc/BRIEF.md
# Batched Complex-Valued Neuron Accumulator

This block evaluates a single hidden-layer neuron of a complex-valued network. A sample of `N_INPUTS` complex input fields is delivered in batches of `LANES` (eight) fields per clock. Each field arrives with its matching complex weight on separate real and imaginary buses. In the same cycle the block forms all eight complex products and reduces them to one complex partial sum. That partial sum is then added into a running complex accumulator built from flip-flops.

A start pulse opens a sample and clears the accumulator and batch counter. Each cycle with `in_valid` high consumes one batch. Once the last batch of the sample has been taken, the complex bias is added a single time. A ReLU is then applied to the real and imaginary components independently, and the result is presented together with a one-cycle `out_valid` pulse. Batches offered while no sample is open are dropped. The multiplier structure can be chosen by parameter: four real multipliers per lane, or a three-multiplier form.

Top module: `cplx_neuron_acc`

## Requirements
- R1: Each lane k takes its operands from bits [k*DW +: DW] of each bus, all as two's complement. It computes (a+jb)(c+jd) as real part ac−bd and imaginary part ad+bc, where a/b are the input's real/imaginary parts and c/d the weight's.
- R2: In one accepted cycle, the eight lane products are summed and added to the accumulator, with the real and imaginary components both updated in that same cycle.
- R3: The accumulator is 2*DW+1+log2(N_INPUTS) bits wide, so a full sample of extreme operand values (including −2^(DW−1)) sums exactly with no wrap.
- R4: A sample completes after N_INPUTS/8 accepted batches (8 for 64 inputs, 16 for 128). `out_valid` stays low in the cycle right after the clock edge that accepts the final batch, and is high in the cycle after the following edge.
- R5: The bias (`b_re`, `b_im`, accumulator width, two's complement) is added exactly once per sample. The output is one bit wider than the accumulator.
- R6: The activation works component by component: `y_re` = max(0, re) and `y_im` = max(0, im), each applied to the biased sum.
- R7: A `start` pulse clears the accumulator and batch counter, even in the middle of a sample. Batches taken before it have no effect on the next result, and `in_valid` in the same cycle as `start` is not accepted.
- R8: `in_valid` while no sample is open is ignored. It produces no `out_valid` and does not change the next sample's result.
- R9: `out_valid` is high for exactly one cycle per completed sample.
- R10: Cycles with `in_valid` low inside a sample stall the accumulation without changing the result.
- R11: After reset, `out_valid` is low and `y_re`, `y_im` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Opens a sample; clears accumulator and counter |
| in_valid | input | 1 | Current batch buses carry data |
| x_re | input | LANES*DW | Input real parts, lane k at [k*DW +: DW] |
| x_im | input | LANES*DW | Input imaginary parts |
| w_re | input | LANES*DW | Weight real parts |
| w_im | input | LANES*DW | Weight imaginary parts |
| b_re | input | ACCW | Bias real part |
| b_im | input | ACCW | Bias imaginary part |
| y_re | output | ACCW+1 | Activated real output |
| y_im | output | ACCW+1 | Activated imaginary output |
| out_valid | output | 1 | One-cycle result strobe |
| busy | output | 1 | A sample is open |

## Verification
The main datapath is driven with four kinds of pattern, each aimed at a different class of error:
- Uniform random operands catch general arithmetic faults.
- Purely real inputs against complex weights separate the cross terms ad and bc from the direct terms ac and bd, so a swapped or wrongly signed product term becomes visible.
- Every operand set to its most negative or largest value exposes truncation of the accumulator.
- Alternating signs with a large negative real bias and a positive imaginary bias clip one component while passing the other, which shows that the activation acts on each component separately.

Idle gaps inside a sample, a restart partway through a sample, and stray batches before and after samples then confirm that only accepted batches of an open sample reach the result.

// File: rtl/cnacc_pkg.sv
package cnacc_pkg;
   // Complex-multiplier structure selectors
   localparam int CMUL_FOUR  = 0;
   localparam int CMUL_THREE = 1;

   typedef enum logic {
      S_IDLE = 1'b0,
      S_RUN  = 1'b1
   } cnacc_state_e;
endpackage

// File: rtl/cnacc_cmul.sv
module cnacc_cmul
   import cnacc_pkg::*;
#(
   parameter int DW    = 8,
   parameter int STYLE = CMUL_FOUR,
   localparam int PW   = 2*DW + 1
) (
   input  logic [DW-1:0] a_re,
   input  logic [DW-1:0] a_im,
   input  logic [DW-1:0] b_re,
   input  logic [DW-1:0] b_im,
   output logic [PW-1:0] p_re,
   output logic [PW-1:0] p_im
);
   // operands sign-extended to product width so every multiply is PW x PW
   logic signed [PW-1:0] xa, xb, xc, xd;
   assign xa = $signed({{(PW-DW){a_re[DW-1]}}, a_re});
   assign xb = $signed({{(PW-DW){a_im[DW-1]}}, a_im});
   assign xc = $signed({{(PW-DW){b_re[DW-1]}}, b_re});
   assign xd = $signed({{(PW-DW){b_im[DW-1]}}, b_im});

   generate
      if (STYLE == CMUL_FOUR) begin : g_four
         logic signed [PW-1:0] m_ac, m_bd, m_ad, m_bc;
         always_comb begin
            m_ac = xa * xc;
            m_bd = xb * xd;
            m_ad = xa * xd;
            m_bc = xb * xc;
         end
         assign p_re = m_ac - m_bd;
         assign p_im = m_ad + m_bc;
      end else begin : g_three
         logic signed [PW-1:0] s_ab, s_dc, s_cd;
         logic signed [PW-1:0] k1, k2, k3;
         always_comb begin
            s_ab = xa + xb;
            s_dc = xd - xc;
            s_cd = xc + xd;
            k1   = xc * s_ab;
            k2   = xa * s_dc;
            k3   = xb * s_cd;
         end
         assign p_re = k1 - k3;
         assign p_im = k1 + k2;
      end
   endgenerate
endmodule

// File: rtl/cnacc_lane_sum.sv
module cnacc_lane_sum #(
   parameter int LANES = 8,
   parameter int PW    = 17,
   localparam int SW   = PW + $clog2(LANES)
) (
   input  logic [LANES*PW-1:0] lanes,
   output logic [SW-1:0]       sum
);
   // sign-extended lane terms, summed in a flat chain the tool may rebalance
   logic [SW-1:0] ext [LANES];

   genvar k;
   generate
      for (k = 0; k < LANES; k++) begin : g_ext
         assign ext[k] = {{(SW-PW){lanes[k*PW+PW-1]}}, lanes[k*PW +: PW]};
      end
   endgenerate

   always_comb begin
      sum = '0;
      for (int i = 0; i < LANES; i++) begin
         sum = sum + ext[i];
      end
   end
endmodule

// File: rtl/cnacc_ctrl.sv
module cnacc_ctrl
   import cnacc_pkg::*;
#(
   parameter int NB  = 8,
   localparam int CW = (NB > 1) ? $clog2(NB) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic in_valid,
   output logic accept,
   output logic fin,
   output logic busy
);
   cnacc_state_e   state;
   logic [CW-1:0]  cnt;
   logic           last;

   assign busy   = (state == S_RUN);
   assign accept = in_valid && busy && !start;
   assign last   = accept && (cnt == CW'(NB-1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_IDLE;
         cnt   <= '0;
         fin   <= 1'b0;
      end else begin
         fin <= last;
         if (start) begin
            state <= S_RUN;
            cnt   <= '0;
         end else if (accept) begin
            if (last) begin
               state <= S_IDLE;
               cnt   <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   // R4: batch index never passes the final batch of a sample
   a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(NB-1));
   // R4: taking the last batch closes the sample
   a_r4_last_closes: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> !busy && fin);
   // R7: start always opens a fresh sample at index zero
   a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy && (cnt == '0));
endmodule

// File: rtl/cnacc_act.sv
module cnacc_act #(
   parameter int AW  = 23,
   localparam int OW = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fin,
   input  logic [AW-1:0] acc_re,
   input  logic [AW-1:0] acc_im,
   input  logic [AW-1:0] b_re,
   input  logic [AW-1:0] b_im,
   output logic [OW-1:0] y_re,
   output logic [OW-1:0] y_im,
   output logic          out_valid
);
   logic [OW-1:0] z_re, z_im;

   assign z_re = {acc_re[AW-1], acc_re} + {b_re[AW-1], b_re};
   assign z_im = {acc_im[AW-1], acc_im} + {b_im[AW-1], b_im};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         y_re      <= '0;
         y_im      <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= fin;
         if (fin) begin
            y_re <= z_re[OW-1] ? '0 : z_re;
            y_im <= z_im[OW-1] ? '0 : z_im;
         end
      end
   end

   // R9: result strobe lasts one cycle
   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);
   // R6: neither presented component is negative
   a_r6_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !y_re[OW-1] && !y_im[OW-1]);
endmodule

// File: rtl/cplx_neuron_acc.sv
module cplx_neuron_acc
   import cnacc_pkg::*;
#(
   parameter int DW        = 8,
   parameter int N_INPUTS  = 64,
   parameter int LANES     = 8,
   parameter int CMUL_MODE = CMUL_FOUR,
   localparam int NB       = N_INPUTS / LANES,
   localparam int PW       = 2*DW + 1,
   localparam int SW       = PW + $clog2(LANES),
   localparam int ACCW     = PW + $clog2(N_INPUTS),
   localparam int OW       = ACCW + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                in_valid,
   input  logic [LANES*DW-1:0] x_re,
   input  logic [LANES*DW-1:0] x_im,
   input  logic [LANES*DW-1:0] w_re,
   input  logic [LANES*DW-1:0] w_im,
   input  logic [ACCW-1:0]     b_re,
   input  logic [ACCW-1:0]     b_im,
   output logic [OW-1:0]       y_re,
   output logic [OW-1:0]       y_im,
   output logic                out_valid,
   output logic                busy
);
   // elaboration-time parameter checks
   initial begin
      assert (DW >= 2) else $error("DW must be at least 2");
      assert (LANES >= 2) else $error("LANES must be at least 2");
      assert (N_INPUTS % LANES == 0) else $error("N_INPUTS must be a multiple of LANES");
      assert (NB >= 2) else $error("a sample needs at least two batches");
      assert (CMUL_MODE == CMUL_FOUR || CMUL_MODE == CMUL_THREE)
         else $error("unknown CMUL_MODE");
   end

   logic [LANES*PW-1:0] prod_re, prod_im;
   logic [SW-1:0]       bsum_re, bsum_im;
   logic [ACCW-1:0]     acc_re, acc_im;
   logic                accept, fin;

   genvar k;
   generate
      for (k = 0; k < LANES; k++) begin : g_lane
         cnacc_cmul #(.DW(DW), .STYLE(CMUL_MODE)) u_mul (
            .a_re (x_re[k*DW +: DW]),
            .a_im (x_im[k*DW +: DW]),
            .b_re (w_re[k*DW +: DW]),
            .b_im (w_im[k*DW +: DW]),
            .p_re (prod_re[k*PW +: PW]),
            .p_im (prod_im[k*PW +: PW])
         );
      end
   endgenerate

   cnacc_lane_sum #(.LANES(LANES), .PW(PW)) u_sum_re (
      .lanes (prod_re),
      .sum   (bsum_re)
   );
   cnacc_lane_sum #(.LANES(LANES), .PW(PW)) u_sum_im (
      .lanes (prod_im),
      .sum   (bsum_im)
   );

   cnacc_ctrl #(.NB(NB)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .in_valid (in_valid),
      .accept   (accept),
      .fin      (fin),
      .busy     (busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_re <= '0;
         acc_im <= '0;
      end else if (start) begin
         acc_re <= '0;
         acc_im <= '0;
      end else if (accept) begin
         acc_re <= acc_re + {{(ACCW-SW){bsum_re[SW-1]}}, bsum_re};
         acc_im <= acc_im + {{(ACCW-SW){bsum_im[SW-1]}}, bsum_im};
      end
   end

   cnacc_act #(.AW(ACCW)) u_act (
      .clk       (clk),
      .rst_n     (rst_n),
      .fin       (fin),
      .acc_re    (acc_re),
      .acc_im    (acc_im),
      .b_re      (b_re),
      .b_im      (b_im),
      .y_re      (y_re),
      .y_im      (y_im),
      .out_valid (out_valid)
   );

   // R8: with no sample open and no start, the accumulator holds
   a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(acc_re) && $stable(acc_im));
   // R7: start empties the accumulator on the next cycle
   a_r7_acc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (acc_re == '0) && (acc_im == '0));
   // R4: a strobe is only produced while no new batch is still pending
   a_r4_valid_after_close: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(fin));
endmodule

// File: tb/sim_cplx_neuron_acc.sv
module sim_cplx_neuron_acc;
   localparam int DW    = 8;
   localparam int NIN   = 64;
   localparam int LANES = 8;
   localparam int NB    = NIN / LANES;
   localparam int ACCW  = 2*DW + 1 + $clog2(NIN);
   localparam int OW    = ACCW + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic in_valid = 1'b0;
   logic [LANES*DW-1:0] x_re = '0, x_im = '0, w_re = '0, w_im = '0;
   logic [ACCW-1:0] b_re = '0, b_im = '0;
   logic [OW-1:0] y_re, y_im;
   logic out_valid, busy;

   always #2 clk = ~clk;   // 250 MHz

   cplx_neuron_acc #(.DW(DW), .N_INPUTS(NIN), .LANES(LANES)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
      .x_re(x_re), .x_im(x_im), .w_re(w_re), .w_im(w_im),
      .b_re(b_re), .b_im(b_im), .y_re(y_re), .y_im(y_im),
      .out_valid(out_valid), .busy(busy)
   );

   int n_chk = 0, n_fail = 0;
   int n_pushed = 0, n_seen = 0;
   bit done = 0;
   longint q_re[$], q_im[$];
   string q_tag[$];
   int xr[NIN], xi[NIN], wr[NIN], wi[NIN];

   task automatic chk(bit ok, string tag, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int rnd();
      return int'($urandom_range(0, 255)) - 128;
   endfunction

   // pattern 0 random, 1 extremes, 2 pure-real inputs, 3 alternating signs
   task automatic fill(int mode);
      for (int i = 0; i < NIN; i++) begin
         case (mode)
            0: begin xr[i] = rnd(); xi[i] = rnd(); wr[i] = rnd(); wi[i] = rnd(); end
            1: begin xr[i] = -128; xi[i] = 127; wr[i] = -128; wi[i] = -128; end
            2: begin xr[i] = rnd(); xi[i] = 0; wr[i] = rnd(); wi[i] = rnd(); end
            default: begin
               xr[i] = (i % 2 == 0) ? 100 : -90; xi[i] = (i % 3 == 0) ? -70 : 60;
               wr[i] = 50 - i; wi[i] = i - 20;
            end
         endcase
      end
   endtask

   task automatic load_batch(int base);
      for (int k = 0; k < LANES; k++) begin
         x_re[k*DW +: DW] = DW'(xr[base+k]);
         x_im[k*DW +: DW] = DW'(xi[base+k]);
         w_re[k*DW +: DW] = DW'(wr[base+k]);
         w_im[k*DW +: DW] = DW'(wi[base+k]);
      end
   endtask

   task automatic push_expected(longint bre, longint bim, string tag);
      longint sr = bre, si = bim;
      for (int i = 0; i < NIN; i++) begin
         sr += longint'(xr[i]) * wr[i] - longint'(xi[i]) * wi[i];
         si += longint'(xr[i]) * wi[i] + longint'(xi[i]) * wr[i];
      end
      q_re.push_back(sr < 0 ? 0 : sr);
      q_im.push_back(si < 0 ? 0 : si);
      q_tag.push_back(tag);
      n_pushed++;
   endtask

   task automatic pulse_start();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   // full sample; gap inserts an idle cycle after every odd batch (R10)
   task automatic run_sample(longint bre, longint bim, bit gap, string tag);
      b_re = ACCW'(bre);
      b_im = ACCW'(bim);
      push_expected(bre, bim, tag);
      pulse_start();
      for (int b = 0; b < NB; b++) begin
         load_batch(b*LANES);
         in_valid = 1'b1;
         @(negedge clk);
         if (gap && (b % 2 == 1) && b != NB-1) begin
            in_valid = 1'b0;
            load_batch(0);
            @(negedge clk);
         end
      end
      in_valid = 1'b0;
      chk(out_valid == 1'b0, "R4 early strobe", longint'(out_valid), 0);
      @(negedge clk);
      chk(out_valid == 1'b1, "R4 strobe timing", longint'(out_valid), 1);
      @(negedge clk);
   endtask

   task automatic stray_batches(int n);
      for (int b = 0; b < n; b++) begin
         fill(0);
         load_batch(0);
         in_valid = 1'b1;
         @(negedge clk);
      end
      in_valid = 1'b0;
   endtask

   // scoreboard monitor
   bit prev_v = 0;
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (out_valid) begin
            n_seen++;
            chk(!prev_v, "R9 strobe width", 2, 1);
            if (q_re.size() == 0) begin
               chk(0, "R8 unexpected result", longint'(y_re), -1);
            end else begin
               longint er, ei;
               string t;
               er = q_re.pop_front();
               ei = q_im.pop_front();
               t  = q_tag.pop_front();
               chk(y_re == OW'(er), {t, " real"}, longint'(y_re), er);
               chk(y_im == OW'(ei), {t, " imag"}, longint'(y_im), ei);
            end
         end
         prev_v = out_valid;
      end
   end

   task automatic finish_run();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(out_valid == 1'b0, "R11 out_valid at reset", longint'(out_valid), 0);
      chk(y_re == '0 && y_im == '0, "R11 outputs at reset", longint'(y_re | y_im), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R8: batches while idle must be dropped
      stray_batches(12);
      repeat (4) @(negedge clk);
      chk(n_seen == 0, "R8 idle batches", n_seen, 0);

      fill(0); run_sample(0, 0, 0, "R1 R2 random");
      fill(2); run_sample(0, 0, 0, "R1 pure-real cross terms");
      fill(1); run_sample(0, 0, 0, "R3 extreme operands");
      fill(0); run_sample(0, 0, 1, "R10 gapped batches");
      fill(3); run_sample(-4000000, 1000, 0, "R5 R6 bias and clip");
      fill(0); run_sample(123456, -77, 0, "R5 bias once");

      // R7: restart in the middle of a sample
      fill(0);
      pulse_start();
      for (int b = 0; b < 3; b++) begin
         load_batch(b*LANES);
         in_valid = 1'b1;
         @(negedge clk);
      end
      in_valid = 1'b0;
      fill(3); run_sample(0, 0, 0, "R7 restart");

      // R8: batches after a completed sample must not leak into the next
      stray_batches(5);
      repeat (3) @(negedge clk);
      chk(n_seen == n_pushed, "R8 trailing batches", n_seen, n_pushed);
      fill(2); run_sample(500, 500, 0, "R8 next sample clean");

      repeat (5) @(negedge clk);
      chk(n_seen == n_pushed, "R9 one strobe per sample", n_seen, n_pushed);
      finish_run();
   end
endmodule